// File: doc/BRIEF.md
# Paired-Channel Combine PWM Timer

The block is an up-counting timer whose two channel-value registers work as a pair and produce one PWM waveform. A prescaler divides the input clock by a power of two and gives the counter an advance tick. The counter runs from a programmable start value up to a programmable end value and then wraps back to the start value. Each wrap raises a sticky overflow flag. The waveform holds its idle level from the start of the period, switches to its active level when the count reaches the first match value, and returns to idle when the count reaches the second match value.

Software programs the block through a small word-wide register port. Any write to the count register, whatever the data, restarts the period from the start value and puts the output back to its idle level. Counting stops when the clock-select field is zero. The pin-enable output tells the pad logic whether the timer owns the pin, and it follows the clock-select field. The start, end and match registers are used from the next clock on. There is no shadow copy of them.

Top module: `pwm_pair_timer`

## Requirements
- R1: After reset the count is 0, every register reads 0, pwmOut is 0, pinEn is 0 and ovfFlag is 0.
- R2: pinEn is 1 exactly when the clock-select field (control register at address 0, bits 1:0) is nonzero.
- R3: While the clock-select field is 0 the count holds its value and the prescaler stays cleared.
- R4: A write of any data to the count register (address 1) loads the count with the start value (address 2) and sets pwmOut to its idle level.
- R5: With clock select nonzero and the prescale field PS (control bits 4:2) set, the count advances by one every 2^PS clocks. The first advance comes 2^PS clocks after the edge that starts the counter.
- R6: On an advance tick while the count equals the end value (address 3), the count reloads the start value, pwmOut returns to idle and ovfFlag (control bit 6) is set.
- R7: Writing the control register with bit 6 = 1 clears ovfFlag. If a wrap sets the flag in the same cycle, the set wins.
- R8: With the polarity bit (control bit 5) at 0, the idle level is 1. pwmOut goes to 0 when the count advances onto match A (address 4) and back to 1 when it advances onto match B (address 5).
- R9: With the polarity bit at 1, the levels are inverted: the idle level is 0 and the active level is 1.
- R10: Writes to the start, end and match registers affect counting and output on the next clock. Every register reads back through rdData at its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | 16 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 16 | Read data for rdAddr |
| pwmOut | output | 1 | Combined channel output level |
| pinEn | output | 1 | Timer owns the pin |
| ovfFlag | output | 1 | Sticky wrap flag |

## Verification
The assertions check on every cycle how the counter responds to a tick, to a restart write and to a stopped clock. They also check that a wrap raises the overflow flag and that a clear write drops it. Only the bench scenarios can show the waveform. These cover the match edges under both polarities, the prescale ratio measured over several periods, restart writes that land mid-period, and register updates that take effect at once. The bench checks all of them against a cycle model under directed and seeded random register traffic.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  typedef struct packed {
    logic tick;
    logic cntReload;
    logic ovfClear;
  } strobe_t;

  typedef enum logic [2:0] {
    ADDR_CTRL   = 3'd0,
    ADDR_COUNT  = 3'd1,
    ADDR_START  = 3'd2,
    ADDR_END    = 3'd3,
    ADDR_MATCHA = 3'd4,
    ADDR_MATCHB = 3'd5
  } addr_e;
endpackage

// File: rtl/pwm_pair_ctrl.sv
module pwm_pair_ctrl
  import pwm_pair_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  output logic [1:0]       clkSel,
  output logic [PS_W-1:0]  psSel,
  output logic             polHigh,
  output logic [CNT_W-1:0] startVal,
  output logic [CNT_W-1:0] endVal,
  output logic [CNT_W-1:0] matchA,
  output logic [CNT_W-1:0] matchB,
  output strobe_t          strobes
);
  localparam int PSC_W   = (1 << PS_W) - 1;
  localparam int PS_LSB  = 2;
  localparam int POL_BIT = PS_LSB + PS_W;
  localparam int OVF_BIT = POL_BIT + 1;

  logic [PSC_W-1:0] psCnt;
  logic [PSC_W-1:0] psMask;
  logic             running;
  logic             wrCtrl;

  assign running = (clkSel != 2'b00);
  assign wrCtrl  = wrEn && (wrAddr == ADDR_CTRL);

  always_comb begin
    psMask = ~({PSC_W{1'b1}} << psSel);
    strobes.tick      = running && ((psCnt & psMask) == psMask);
    strobes.cntReload = wrEn && (wrAddr == ADDR_COUNT);
    strobes.ovfClear  = wrCtrl && wrData[OVF_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCnt <= '0;
    end else if (!running || strobes.tick) begin
      psCnt <= '0;
    end else begin
      psCnt <= psCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSel   <= '0;
      psSel    <= '0;
      polHigh  <= 1'b0;
      startVal <= '0;
      endVal   <= '0;
      matchA   <= '0;
      matchB   <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_CTRL: begin
          clkSel  <= wrData[1:0];
          psSel   <= wrData[PS_LSB +: PS_W];
          polHigh <= wrData[POL_BIT];
        end
        ADDR_START:  startVal <= wrData;
        ADDR_END:    endVal   <= wrData;
        ADDR_MATCHA: matchA   <= wrData;
        ADDR_MATCHB: matchB   <= wrData;
        default: ;
      endcase
    end
  end

  // R3: a stopped clock select leaves the prescaler cleared
  a_r3_prescale_idle: assert property (@(posedge clk) disable iff (!rstN)
    !running |=> (psCnt == '0));
endmodule

// File: rtl/pwm_pair_datapath.sv
module pwm_pair_datapath
  import pwm_pair_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic             polHigh,
  input  logic [CNT_W-1:0] startVal,
  input  logic [CNT_W-1:0] endVal,
  input  logic [CNT_W-1:0] matchA,
  input  logic [CNT_W-1:0] matchB,
  output logic [CNT_W-1:0] count,
  output logic             chanOut,
  output logic             ovfFlag
);
  logic             idleLvl;
  logic             atEnd;
  logic [CNT_W-1:0] nextCnt;

  assign idleLvl = ~polHigh;
  assign atEnd   = (count == endVal);
  assign nextCnt = count + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      chanOut <= 1'b0;
    end else if (strobes.cntReload) begin
      count   <= startVal;
      chanOut <= idleLvl;
    end else if (strobes.tick) begin
      if (atEnd) begin
        count   <= startVal;
        chanOut <= idleLvl;
      end else begin
        count <= nextCnt;
        if (nextCnt == matchA)      chanOut <= ~idleLvl;
        else if (nextCnt == matchB) chanOut <= idleLvl;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                          ovfFlag <= 1'b0;
    else if (strobes.tick && atEnd && !strobes.cntReload) ovfFlag <= 1'b1;
    else if (strobes.ovfClear)                          ovfFlag <= 1'b0;
  end

  // R4: restart write loads the start value
  a_r4_reload: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cntReload |=> (count == $past(startVal)));
  // R3: no tick and no restart, count holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.tick && !strobes.cntReload) |=> $stable(count));
  // R5: a tick away from the end value steps by one
  a_r5_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.tick && !strobes.cntReload && !atEnd) |=> (count == $past(count) + 1'b1));
  // R6: wrap sets the flag
  a_r6_wrap_flag: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.tick && atEnd && !strobes.cntReload) |=> ovfFlag);
  // R7: clear without a coinciding wrap drops the flag
  a_r7_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ovfClear && !(strobes.tick && atEnd)) |=> !ovfFlag);
endmodule

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer
  import pwm_pair_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [2:0]       rdAddr,
  output logic [CNT_W-1:0] rdData,
  output logic             pwmOut,
  output logic             pinEn,
  output logic             ovfFlag
);
  localparam int POL_BIT = 2 + PS_W;
  localparam int OVF_BIT = POL_BIT + 1;

  strobe_t          strobes;
  logic [1:0]       clkSel;
  logic [PS_W-1:0]  psSel;
  logic             polHigh;
  logic [CNT_W-1:0] startVal, endVal, matchA, matchB, count;
  logic [CNT_W-1:0] ctrlWord;

  pwm_pair_ctrl #(.CNT_W(CNT_W), .PS_W(PS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .clkSel(clkSel), .psSel(psSel), .polHigh(polHigh), .startVal(startVal),
    .endVal(endVal), .matchA(matchA), .matchB(matchB), .strobes(strobes)
  );

  pwm_pair_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .polHigh(polHigh),
    .startVal(startVal), .endVal(endVal), .matchA(matchA), .matchB(matchB),
    .count(count), .chanOut(pwmOut), .ovfFlag(ovfFlag)
  );

  assign pinEn = (clkSel != 2'b00);

  always_comb begin
    ctrlWord = '0;
    ctrlWord[1:0]          = clkSel;
    ctrlWord[2 +: PS_W]    = psSel;
    ctrlWord[POL_BIT]      = polHigh;
    ctrlWord[OVF_BIT]      = ovfFlag;
    case (rdAddr)
      ADDR_CTRL:   rdData = ctrlWord;
      ADDR_COUNT:  rdData = count;
      ADDR_START:  rdData = startVal;
      ADDR_END:    rdData = endVal;
      ADDR_MATCHA: rdData = matchA;
      ADDR_MATCHB: rdData = matchB;
      default:     rdData = '0;
    endcase
  end
endmodule

// File: tb/test_pwm_pair_timer.sv
module test_pwm_pair_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        pwmOut, pinEn, ovfFlag;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  pwm_pair_timer i_pwm_pair_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .pwmOut(pwmOut), .pinEn(pinEn), .ovfFlag(ovfFlag)
  );

  always #10 clk = ~clk;

  // reference model state
  logic [1:0]  mClk = '0;
  logic [2:0]  mPs = '0;
  logic        mPol = 1'b0;
  logic [15:0] mStart = '0, mEnd = '0, mA = '0, mB = '0, mCnt = '0;
  logic [6:0]  mPsCnt = '0;
  logic        mOut = 1'b0, mOvf = 1'b0;

  function automatic logic [15:0] modelRead(input logic [2:0] a);
    case (a)
      3'd0: return {9'd0, mOvf, mPol, mPs, mClk};
      3'd1: return mCnt;
      3'd2: return mStart;
      3'd3: return mEnd;
      3'd4: return mA;
      3'd5: return mB;
      default: return 16'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mClk = '0; mPs = '0; mPol = 0; mStart = '0; mEnd = '0; mA = '0; mB = '0;
      mCnt = '0; mPsCnt = '0; mOut = 0; mOvf = 0;
    end else begin
      logic [6:0] mask;
      logic tick, reload, clr, idle, wrap;
      logic [15:0] nxt;
      mask   = 7'((1 << mPs) - 1);
      tick   = (mClk != 0) && ((mPsCnt & mask) == mask);
      reload = wrEn && wrAddr == 3'd1;
      clr    = wrEn && wrAddr == 3'd0 && wrData[6];
      idle   = !mPol;
      wrap   = (mCnt == mEnd);
      nxt    = mCnt + 16'd1;
      mPsCnt = (mClk == 0 || tick) ? 7'd0 : mPsCnt + 7'd1;
      if (tick && wrap && !reload) mOvf = 1;
      else if (clr) mOvf = 0;
      if (reload) begin
        mCnt = mStart; mOut = idle;
      end else if (tick) begin
        if (wrap) begin
          mCnt = mStart; mOut = idle;
        end else begin
          mCnt = nxt;
          if (nxt == mA) mOut = !idle;
          else if (nxt == mB) mOut = idle;
        end
      end
      if (wrEn) begin
        case (wrAddr)
          3'd0: begin mClk = wrData[1:0]; mPs = wrData[4:2]; mPol = wrData[5]; end
          3'd2: mStart = wrData;
          3'd3: mEnd = wrData;
          3'd4: mA = wrData;
          3'd5: mB = wrData;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string rdTag);
    chk(mPol ? "R9 pwmOut" : "R8 pwmOut", 16'(pwmOut), 16'(mOut));
    chk("R2 pinEn", 16'(pinEn), 16'(mClk != 0));
    chk("R6 ovfFlag", 16'(ovfFlag), 16'(mOvf));
    chk(rdTag, rdData, modelRead(rdAddr));
  endtask

  task automatic step(input string rdTag);
    @(negedge clk);
    checkAll(rdTag);
    wrEn = 0;
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [15:0] d, input string rdTag);
    wrEn = 1; wrAddr = a; wrData = d;
    step(rdTag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pwmOut", 16'(pwmOut), 16'd0);
    chk("R1 pinEn", 16'(pinEn), 16'd0);
    chk("R1 ovfFlag", 16'(ovfFlag), 16'd0);
    for (int a = 0; a < 6; a++) begin
      rdAddr = 3'(a); #1;
      chk("R1 register", rdData, 16'd0);
    end
    rdAddr = 3'd1;
    writeReg(3'd2, 16'h0010, "R10");
    writeReg(3'd3, 16'h001A, "R10");
    writeReg(3'd4, 16'h0015, "R10");
    writeReg(3'd5, 16'h0018, "R10");
    writeReg(3'd1, 16'hBEEF, "R4");
    chk("R4 count loaded", rdData, 16'h0010);
    chk("R4 idle level", 16'(pwmOut), 16'd1);
    chk("R2 pin off while stopped", 16'(pinEn), 16'd0);
    repeat (5) step("R3");
    chk("R3 count held", rdData, 16'h0010);
    writeReg(3'd0, 16'h0009, "R5"); // clkSel=1, PS=2
    repeat (8) step("R5");
    chk("R5 divide by 4", rdData, 16'h0012);
    writeReg(3'd0, 16'h0001, "R5"); // PS=0
    repeat (40) step("R8");
    chk("R6 wrap flag set", 16'(ovfFlag), 16'd1);
    writeReg(3'd0, 16'h0041, "R7");
    chk("R7 flag cleared", 16'(ovfFlag), 16'd0);
    writeReg(3'd0, 16'h0021, "R9"); // high-true
    writeReg(3'd1, 16'h0000, "R4");
    chk("R9 idle low", 16'(pwmOut), 16'd0);
    repeat (30) step("R9");
    // random phase, fixed seed
    void'($urandom(32'h5EED));
    for (int i = 0; i < 4000; i++) begin
      rdAddr = 3'($urandom_range(0, 5));
      if ($urandom_range(0, 7) == 0) begin
        int sel;
        logic [15:0] d;
        sel = $urandom_range(0, 5);
        case (sel)
          0: d = 16'({$urandom_range(0,1), $urandom_range(0,1), 3'($urandom_range(0,2)), 2'($urandom_range(0,3))});
          2: d = 16'($urandom_range(0, 6));
          3: d = 16'($urandom_range(20, 40));
          4: d = 16'($urandom_range(7, 12));
          5: d = 16'($urandom_range(13, 19));
          default: d = 16'($urandom);
        endcase
        writeReg(3'(sel), d, "R10");
      end else begin
        step("R10");
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule